// File: doc/BRIEF.md
# Instruction Cache Way-Entry Parity Checker

This block examines one way entry of an instruction cache as it is read out. A tag read carries a 32-bit high word and a 64-bit low word. A data read carries a 17-bit side field and two 32-bit instructions. Each read arrives with its own one-cycle strobe. The protection layout is not uniform. The valid bit has its own parity copy. The virtual tag is covered by two parity bits over separate ranges of the low word. The predecode byte has one parity bit. Each instruction has a nibble of even byte parity.

A scan covers one line. The scan is opened with a start pulse, and the four data entries of the line (offsets 0 to 3) are then strobed in. Tag reads may arrive at any point in the scan. Every check that fails sets a sticky bit in a detail vector. Two summary flags report a tag-parity fault and a data-parity fault. A single-cycle done pulse marks the fourth data entry, and a new start pulse clears the results.

Top module: `icache_parity_scan`

## Requirements
- R1: A tag read whose valid bit (tag_hi bit 29) differs from its copy (tag_hi bit 27) sets detail bit 0 and tag_err, whether or not the entry is valid.
- R2: For a valid tag read, tag_lo bit 10 must equal the XOR of tag_lo bits 23:0 with bits 11 and 10 left out. A mismatch sets detail bit 1 and tag_err.
- R3: For a valid tag read, tag_lo bit 11 must equal the XOR of tag_lo bits 63:24. A mismatch sets detail bit 2 and tag_err.
- R4: For an entry whose valid bit is 0, the two range checks of R2 and R3 have no effect. Only R1 can flag such an entry.
- R5: For a data read, side bit 16 must equal the XOR of the predecode byte in side bits 15:8. A mismatch sets detail bit 3 and data_err.
- R6: Side bits 7:4 hold even parity of the bytes of instruction A, with side bit 4+k covering bits 8k+7:8k. Any mismatch sets detail bit 4 and data_err.
- R7: Side bits 3:0 hold even parity of the bytes of instruction B, with side bit k covering bits 8k+7:8k. Any mismatch sets detail bit 5 and data_err.
- R8: Detail bits, tag_err and data_err stay set for the rest of a scan. tag_err is the OR of detail bits 2:0, and data_err is the OR of detail bits 5:3. All of these appear in the cycle after the strobe edge.
- R9: scan_start clears the detail vector, both flags and the offset. A strobe in the same cycle as scan_start counts as the first item of the new scan.
- R10: dat_ofs gives the offset of the next data entry. It starts at 0, advances by one on each data strobe, and wraps from 3 back to 0.
- R11: scan_done is high for exactly one cycle, in the cycle after the data strobe taken at offset 3.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_start | input | 1 | Opens a new line scan and clears the results |
| tag_vld | input | 1 | Strobe for the tag read |
| tag_hi | input | 32 | High tag word, holding the valid bit and its copy |
| tag_lo | input | 64 | Low tag word, holding the virtual tag and its two parity bits |
| dat_vld | input | 1 | Strobe for the data read |
| dat_side | input | 17 | Side field: predecode parity, predecode byte, and the A and B parity nibbles |
| dat_insa | input | 32 | Instruction A |
| dat_insb | input | 32 | Instruction B |
| tag_err | output | 1 | Sticky tag-parity fault |
| data_err | output | 1 | Sticky data-parity fault |
| detail | output | 6 | Sticky per-check fault bits |
| dat_ofs | output | 2 | Offset of the next data entry |
| scan_done | output | 1 | One-cycle pulse after the fourth data entry |

## Verification
Every result register is visible at the ports one cycle after the strobe that writes it. A lost sticky bit or a stale bit left over from the previous scan therefore shows at the next sample, both in the detail vector and in the summary flags. A slipped offset counter first shows up as a wrong dat_ofs value. Within at most four data strobes it also shows up as a missing or misplaced scan_done pulse. The random scans mix single-bit faults into both halves of the layout, and each fault is compared against a bit-level model. A check wired to the wrong range or the wrong nibble position therefore produces a wrong detail bit.

// File: rtl/icp_pkg.sv
package icp_pkg;
   // positions inside the detail vector
   localparam int unsigned DET_VCOPY   = 0;
   localparam int unsigned DET_VTAG_LO = 1;
   localparam int unsigned DET_VTAG_HI = 2;
   localparam int unsigned DET_PDEC    = 3;
   localparam int unsigned DET_INS_A   = 4;
   localparam int unsigned DET_INS_B   = 5;
   localparam int unsigned DET_W       = 6;
   localparam int unsigned TAG_DET_W   = 3;
   localparam int unsigned DAT_DET_W   = DET_W - TAG_DET_W;

   typedef logic [TAG_DET_W-1:0] tag_det_t;
   typedef logic [DAT_DET_W-1:0] dat_det_t;
endpackage

// File: rtl/icp_tag_chk.sv
module icp_tag_chk
   import icp_pkg::*;
#(
   parameter int unsigned HI_W      = 32,
   parameter int unsigned LO_W      = 64,
   parameter int unsigned VALID_POS = 29,
   parameter int unsigned VCOPY_POS = 27,
   parameter int unsigned P0_POS    = 10,
   parameter int unsigned P1_POS    = 11,
   parameter int unsigned SPLIT_POS = 24
) (
   input  logic [HI_W-1:0] tag_hi,
   input  logic [LO_W-1:0] tag_lo,
   output tag_det_t        det
);
   localparam logic [LO_W-1:0] ONE      = LO_W'(1);
   localparam logic [LO_W-1:0] ALL      = {LO_W{1'b1}};
   localparam logic [LO_W-1:0] LOW_SPAN = ~(ALL << SPLIT_POS);
   localparam logic [LO_W-1:0] R0_MASK  = LOW_SPAN & ~(ONE << P0_POS) & ~(ONE << P1_POS);
   localparam logic [LO_W-1:0] R1_MASK  = ALL << SPLIT_POS;

   if (SPLIT_POS <= P0_POS || SPLIT_POS <= P1_POS || SPLIT_POS >= LO_W) begin : g_bad_split
      $error("icp_tag_chk: parity bits must sit below the range split inside the low word");
   end
   if (VALID_POS >= HI_W || VCOPY_POS >= HI_W || VALID_POS == VCOPY_POS) begin : g_bad_valid
      $error("icp_tag_chk: valid bit and its copy must be distinct bits of the high word");
   end

   logic line_valid;
   logic unused_hi;

   assign line_valid = tag_hi[VALID_POS];
   assign unused_hi  = ^tag_hi;

   always_comb begin
      det              = '0;
      det[DET_VCOPY]   = tag_hi[VALID_POS] ^ tag_hi[VCOPY_POS];
      det[DET_VTAG_LO] = line_valid & (tag_lo[P0_POS] ^ (^(tag_lo & R0_MASK)));
      det[DET_VTAG_HI] = line_valid & (tag_lo[P1_POS] ^ (^(tag_lo & R1_MASK)));
   end
endmodule

// File: rtl/icp_data_chk.sv
module icp_data_chk
   import icp_pkg::*;
#(
   parameter int unsigned INS_W = 32,
   parameter int unsigned PD_W  = 8
) (
   input  logic [1+PD_W+2*(INS_W/8)-1:0] side,
   input  logic [INS_W-1:0]              ins_a,
   input  logic [INS_W-1:0]              ins_b,
   output dat_det_t                      det
);
   localparam int unsigned BYTES  = INS_W / 8;
   localparam int unsigned SIDE_W = 1 + PD_W + 2 * BYTES;
   localparam int unsigned NIB_A  = BYTES;
   localparam int unsigned PD_LO  = 2 * BYTES;
   localparam int unsigned PD_PAR = SIDE_W - 1;

   if (INS_W % 8 != 0 || INS_W == 0) begin : g_bad_ins
      $error("icp_data_chk: instruction width must be a whole number of bytes");
   end
   if (PD_W == 0) begin : g_bad_pd
      $error("icp_data_chk: predecode field must be at least one bit");
   end

   logic [1:0][INS_W-1:0] ins;
   logic [1:0][BYTES-1:0] calc;

   assign ins = {ins_b, ins_a};

   for (genvar gi = 0; gi < 2; gi++) begin : g_ins
      for (genvar gb = 0; gb < BYTES; gb++) begin : g_byte
         assign calc[gi][gb] = ^ins[gi][gb*8 +: 8];
      end
   end

   assign det[DET_PDEC - TAG_DET_W]  = side[PD_PAR] ^ (^side[PD_LO +: PD_W]);
   assign det[DET_INS_A - TAG_DET_W] = |(side[NIB_A +: BYTES] ^ calc[0]);
   assign det[DET_INS_B - TAG_DET_W] = |(side[0 +: BYTES] ^ calc[1]);
endmodule

// File: rtl/icp_scan_ctl.sv
module icp_scan_ctl #(
   parameter int unsigned ENTRIES = 4,
   localparam int unsigned OFS_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             strobe,
   output logic [OFS_W-1:0] ofs,
   output logic             done
);
   localparam logic [OFS_W-1:0] LAST = OFS_W'(ENTRIES - 1);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("icp_scan_ctl: a line needs at least two data entries");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs  <= '0;
         done <= 1'b0;
      end else begin
         done <= strobe && !start && (ofs == LAST);
         if (start) begin
            ofs <= strobe ? OFS_W'(1) : '0;
         end else if (strobe) begin
            ofs <= (ofs == LAST) ? '0 : ofs + OFS_W'(1);
         end
      end
   end
endmodule

// File: rtl/icache_parity_scan.sv
module icache_parity_scan
   import icp_pkg::*;
#(
   parameter int unsigned HI_W      = 32,
   parameter int unsigned LO_W      = 64,
   parameter int unsigned VALID_POS = 29,
   parameter int unsigned VCOPY_POS = 27,
   parameter int unsigned P0_POS    = 10,
   parameter int unsigned P1_POS    = 11,
   parameter int unsigned SPLIT_POS = 24,
   parameter int unsigned INS_W     = 32,
   parameter int unsigned PD_W      = 8,
   parameter int unsigned ENTRIES   = 4,
   localparam int unsigned SIDE_W   = 1 + PD_W + 2 * (INS_W / 8),
   localparam int unsigned OFS_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_start,
   input  logic              tag_vld,
   input  logic [HI_W-1:0]   tag_hi,
   input  logic [LO_W-1:0]   tag_lo,
   input  logic              dat_vld,
   input  logic [SIDE_W-1:0] dat_side,
   input  logic [INS_W-1:0]  dat_insa,
   input  logic [INS_W-1:0]  dat_insb,
   output logic              tag_err,
   output logic              data_err,
   output logic [DET_W-1:0]  detail,
   output logic [OFS_W-1:0]  dat_ofs,
   output logic              scan_done
);
   tag_det_t tag_det_n, tag_det_q;
   dat_det_t dat_det_n, dat_det_q;

   icp_tag_chk #(
      .HI_W(HI_W), .LO_W(LO_W), .VALID_POS(VALID_POS), .VCOPY_POS(VCOPY_POS),
      .P0_POS(P0_POS), .P1_POS(P1_POS), .SPLIT_POS(SPLIT_POS)
   ) tag_chk_i (
      .tag_hi(tag_hi),
      .tag_lo(tag_lo),
      .det   (tag_det_n)
   );

   icp_data_chk #(
      .INS_W(INS_W), .PD_W(PD_W)
   ) data_chk_i (
      .side (dat_side),
      .ins_a(dat_insa),
      .ins_b(dat_insb),
      .det  (dat_det_n)
   );

   icp_scan_ctl #(
      .ENTRIES(ENTRIES)
   ) scan_ctl_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (scan_start),
      .strobe(dat_vld),
      .ofs   (dat_ofs),
      .done  (scan_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_det_q <= '0;
         dat_det_q <= '0;
      end else begin
         if (scan_start || tag_vld) begin
            tag_det_q <= (scan_start ? tag_det_t'(0) : tag_det_q) |
                         (tag_vld ? tag_det_n : tag_det_t'(0));
         end
         if (scan_start || dat_vld) begin
            dat_det_q <= (scan_start ? dat_det_t'(0) : dat_det_q) |
                         (dat_vld ? dat_det_n : dat_det_t'(0));
         end
      end
   end

   assign detail   = {dat_det_q, tag_det_q};
   assign tag_err  = |tag_det_q;
   assign data_err = |dat_det_q;
endmodule

// File: rtl/icp_checker.sv
module icp_checker #(
   parameter int unsigned HI_W      = 32,
   parameter int unsigned VALID_POS = 29,
   parameter int unsigned VCOPY_POS = 27,
   parameter int unsigned SIDE_W    = 17,
   parameter int unsigned PD_W      = 8,
   parameter int unsigned DET_W     = 6,
   parameter int unsigned OFS_W     = 2,
   parameter int unsigned ENTRIES   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scan_start,
   input logic              tag_vld,
   input logic [HI_W-1:0]   tag_hi,
   input logic              dat_vld,
   input logic [SIDE_W-1:0] dat_side,
   input logic              tag_err,
   input logic              data_err,
   input logic [DET_W-1:0]  detail,
   input logic [OFS_W-1:0]  dat_ofs,
   input logic              scan_done
);
   localparam logic [OFS_W-1:0] LAST = OFS_W'(ENTRIES - 1);
   localparam int unsigned PD_LO = SIDE_W - 1 - PD_W;

   // R1
   vcopy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_vld && (tag_hi[VALID_POS] != tag_hi[VCOPY_POS]) |=> tag_err && detail[0]);

   // R4
   invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_vld && scan_start && !tag_hi[VALID_POS] && !tag_hi[VCOPY_POS] |=> !tag_err);

   // R5
   pdec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_vld && (dat_side[SIDE_W-1] != ^dat_side[PD_LO +: PD_W]) |=> data_err && detail[3]);

   // R8
   tag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_err && !scan_start |=> tag_err);

   // R8
   data_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_err && !scan_start |=> data_err);

   // R9
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_start && !tag_vld && !dat_vld |=> !tag_err && !data_err && (dat_ofs == '0));

   // R10
   ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_vld && !scan_start |=> dat_ofs == ((dat_ofs == '0) ? OFS_W'(1) : dat_ofs) || $past(dat_ofs) == LAST || dat_ofs == OFS_W'($past(dat_ofs) + OFS_W'(1)));

   // R11
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> $past(dat_vld) && ($past(dat_ofs) == LAST) && !$past(scan_start));

   // R11
   done_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_vld && !scan_start && (dat_ofs == LAST) |=> scan_done && (dat_ofs == '0));

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> !scan_done);
endmodule

bind icache_parity_scan icp_checker #(
   .HI_W(HI_W), .VALID_POS(VALID_POS), .VCOPY_POS(VCOPY_POS), .SIDE_W(SIDE_W),
   .PD_W(PD_W), .DET_W(icp_pkg::DET_W), .OFS_W(OFS_W), .ENTRIES(ENTRIES)
) chk_i (.*);

// File: tb/icache_parity_scan_tb.sv
`timescale 1ns/1ps
module icache_parity_scan_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scan_start = 1'b0;
   logic        tag_vld = 1'b0;
   logic [31:0] tag_hi = '0;
   logic [63:0] tag_lo = '0;
   logic        dat_vld = 1'b0;
   logic [16:0] dat_side = '0;
   logic [31:0] dat_insa = '0;
   logic [31:0] dat_insb = '0;
   logic        tag_err, data_err, scan_done;
   logic [5:0]  detail;
   logic [1:0]  dat_ofs;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [2:0] e_t = '0;
   logic [2:0] e_d = '0;
   int         e_cnt = 0;

   always #10 clk = ~clk;

   icache_parity_scan dut_i (
      .clk(clk), .rst_n(rst_n), .scan_start(scan_start),
      .tag_vld(tag_vld), .tag_hi(tag_hi), .tag_lo(tag_lo),
      .dat_vld(dat_vld), .dat_side(dat_side), .dat_insa(dat_insa), .dat_insb(dat_insb),
      .tag_err(tag_err), .data_err(data_err), .detail(detail),
      .dat_ofs(dat_ofs), .scan_done(scan_done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bit-level models of the checks
   function automatic logic [2:0] m_tag(input logic [31:0] hi, input logic [63:0] lo);
      logic p = 1'b0;
      logic q = 1'b0;
      logic v = hi[29];
      for (int i = 0; i < 24; i++) if (i != 10 && i != 11) p ^= lo[i];
      for (int i = 24; i < 64; i++) q ^= lo[i];
      return {v && (q != lo[11]), v && (p != lo[10]), hi[29] != hi[27]};
   endfunction

   function automatic logic [3:0] m_nib(input logic [31:0] w);
      logic [3:0] n = '0;
      for (int k = 0; k < 4; k++)
         for (int j = 0; j < 8; j++) n[k] ^= w[8*k+j];
      return n;
   endfunction

   function automatic logic [2:0] m_dat(input logic [16:0] sd, input logic [31:0] a, input logic [31:0] b);
      logic p = 1'b0;
      for (int i = 8; i < 16; i++) p ^= sd[i];
      return {sd[3:0] != m_nib(b), sd[7:4] != m_nib(a), sd[16] != p};
   endfunction

   function automatic logic [63:0] fix_lo(input logic [63:0] lo);
      logic [63:0] r = lo;
      logic p = 1'b0;
      logic q = 1'b0;
      for (int i = 0; i < 24; i++) if (i != 10 && i != 11) p ^= r[i];
      for (int i = 24; i < 64; i++) q ^= r[i];
      r[10] = p;
      r[11] = q;
      return r;
   endfunction

   function automatic logic [16:0] mk_side(input logic [7:0] pd, input logic [31:0] a, input logic [31:0] b);
      return {^pd, pd, m_nib(a), m_nib(b)};
   endfunction

   task automatic step(input string req, input logic st, input logic tv, input logic dv,
                       input logic [31:0] hi, input logic [63:0] lo,
                       input logic [16:0] sd, input logic [31:0] a, input logic [31:0] b);
      logic dn;
      @(negedge clk);
      scan_start = st; tag_vld = tv; dat_vld = dv;
      tag_hi = hi; tag_lo = lo; dat_side = sd; dat_insa = a; dat_insb = b;
      dn = dv && !st && (e_cnt == 3);
      if (st) begin e_t = '0; e_d = '0; e_cnt = 0; end
      if (tv) e_t |= m_tag(hi, lo);
      if (dv) begin e_d |= m_dat(sd, a, b); e_cnt = (e_cnt + 1) % 4; end
      @(negedge clk);
      scan_start = 0; tag_vld = 0; dat_vld = 0;
      chk({req, " detail"}, 32'(detail), 32'({e_d, e_t}));
      chk({req, " tag_err"}, 32'(tag_err), 32'(|e_t));
      chk({req, " data_err"}, 32'(data_err), 32'(|e_d));
      chk({req, " dat_ofs (R10)"}, 32'(dat_ofs), 32'(e_cnt));
      chk({req, " scan_done (R11)"}, 32'(scan_done), 32'(dn));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] hv;
      logic [63:0] lv;
      logic [31:0] av, bv;
      logic [16:0] sv;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 detail", 32'(detail), 0);
      chk("R12 flags", 32'({tag_err, data_err, scan_done}), 0);
      chk("R12 dat_ofs", 32'(dat_ofs), 0);
      rst_n = 1'b1;
      @(negedge clk);

      hv = 32'h2800_0000; // valid and copy both set
      lv = fix_lo(64'h1234_5678_9abc_def0);
      step("R1 clean", 1, 1, 0, hv, lv, '0, '0, '0);
      chk("R1 clean tag_err", 32'(tag_err), 0);
      step("R1 valid copy mismatch", 1, 1, 0, hv ^ 32'h0800_0000, lv, '0, '0, '0);
      chk("R1 detail bit0", 32'(detail[0]), 1);
      step("R1 invalid copy mismatch", 1, 1, 0, 32'h0800_0000, lv, '0, '0, '0);
      chk("R1 invalid mismatch flag", 32'(tag_err), 1);
      step("R4 invalid bad ranges", 1, 1, 0, 32'h0000_0000, lv ^ 64'h0000_0100_0000_0020, '0, '0, '0);
      chk("R4 no flag", 32'(tag_err), 0);
      step("R2 low range", 1, 1, 0, hv, lv ^ 64'h8, '0, '0, '0);
      chk("R2 detail bit1", 32'(detail), 32'h2);
      step("R2 stored bit", 1, 1, 0, hv, lv ^ 64'h400, '0, '0, '0);
      chk("R2 stored bit detail", 32'(detail), 32'h2);
      step("R3 stored bit", 1, 1, 0, hv, lv ^ 64'h800, '0, '0, '0);
      chk("R3 detail bit2", 32'(detail), 32'h4);
      step("R3 high range", 1, 1, 0, hv, lv ^ 64'h0004_0000_0000_0000, '0, '0, '0);
      chk("R3 high detail", 32'(detail), 32'h4);

      av = 32'hDEAD_BEEF; bv = 32'h0123_4567;
      sv = mk_side(8'h5A, av, bv);
      step("R5 clean", 1, 0, 1, '0, '0, sv, av, bv);
      chk("R5 clean data_err", 32'(data_err), 0);
      step("R5 parity bit", 1, 0, 1, '0, '0, sv ^ 17'h10000, av, bv);
      chk("R5 detail bit3", 32'(detail), 32'h8);
      step("R5 predecode bit", 1, 0, 1, '0, '0, sv ^ 17'h00200, av, bv);
      step("R6 byte fault", 1, 0, 1, '0, '0, sv, av ^ 32'h0001_0000, bv);
      chk("R6 detail bit4", 32'(detail), 32'h10);
      step("R6 msb mapping", 1, 0, 1, '0, '0, sv ^ 17'h00080, av ^ 32'h8000_0000, bv);
      chk("R6 msb mapping no flag", 32'(data_err), 0);
      step("R7 byte fault", 1, 0, 1, '0, '0, sv, av, bv ^ 32'h0000_0100);
      chk("R7 detail bit5", 32'(detail), 32'h20);
      step("R7 lsb mapping", 1, 0, 1, '0, '0, sv ^ 17'h00001, av, bv ^ 32'h0000_0001);
      chk("R7 lsb mapping no flag", 32'(data_err), 0);

      // R8 R10 R11 full scan, fault only at offset 1
      step("R9 start idle", 1, 0, 0, '0, '0, '0, '0, '0);
      step("R10 ofs0", 0, 0, 1, '0, '0, sv, av, bv);
      step("R8 ofs1 fault", 0, 0, 1, '0, '0, sv ^ 17'h10000, av, bv);
      step("R8 ofs2 sticky", 0, 1, 1, hv, lv, sv, av, bv);
      chk("R8 still flagged", 32'(data_err), 1);
      step("R11 ofs3", 0, 0, 1, '0, '0, sv, av, bv);
      chk("R11 done pulse", 32'(scan_done), 1);
      step("R11 after", 0, 0, 0, '0, '0, '0, '0, '0);
      chk("R11 single cycle", 32'(scan_done), 0);
      step("R9 start with strobes", 1, 1, 1, hv, lv ^ 64'h1, sv, av, bv);
      chk("R9 ofs after start", 32'(dat_ofs), 1);

      for (int it = 0; it < 400; it++) begin
         logic st, tv, dv;
         st = ($urandom % 8) == 0;
         tv = $urandom % 2;
         dv = $urandom % 2;
         hv = $urandom;
         hv[27] = hv[29];
         lv = fix_lo({$urandom, $urandom});
         av = $urandom; bv = $urandom;
         sv = mk_side(8'($urandom), av, bv);
         if ($urandom % 4 == 0) hv[$urandom % 32] ^= 1'b1;
         if ($urandom % 4 == 0) lv[$urandom % 64] ^= 1'b1;
         if ($urandom % 4 == 0) sv[$urandom % 17] ^= 1'b1;
         if ($urandom % 6 == 0) av[$urandom % 32] ^= 1'b1;
         step("R8 random", st, tv, dv, hv, lv, sv, av, bv);
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule